// File: doc/BRIEF.md
# UART receiver with programmable sample point

This block receives asynchronous serial frames on a single line, using a system clock that runs many times faster than the bit rate. Software-visible configuration inputs select the clock count per bit, the data length (5 to 9 bits), the parity mode, the bit order, optional inversion of the line and the position inside each bit at which the line is read, given as a percentage of the bit period. The line is read once per bit. All bit positions are measured from the clock at which the start edge was seen.

After the stop bit, or after a start bit that turns out to be false, the block pulses a one-cycle strobe. With the strobe it presents the assembled word, a frame-good flag and two error causes: framing and parity. These outputs hold their values until the next strobe. The configuration is captured when a frame begins, so a host may rewrite it at any time without corrupting the frame in flight.

Top module: `uart_sp_rx`

## Requirements
- R1: While and after reset, and until the first frame completes, `rx_strobe`, `rx_word`, `rx_frame_ok`, `rx_frame_err` and `rx_parity_err` are all 0.
- R2: The line passes through a two-flop synchronizer. In idle, a high-to-low transition of the normalized synchronized line sets the frame origin t0. Slot n (0 is the start bit, 1..L are data, then parity if enabled, then stop) is read at clock t0 + n*cfg_cpb + off, where off = floor((cfg_cpb-1)*pct/100). Each frame result appears on the outputs one clock after the stop read. cfg_cpb must be at least 2.
- R3: A `cfg_pct` value of 0 or above 99 is used as 50.
- R4: If the start slot reads 1, the block pulses `rx_strobe` with `rx_word`=0, `rx_frame_ok`=0, `rx_frame_err`=1 and `rx_parity_err`=0, then returns to idle.
- R5: `cfg_len` values 5 to 9 set the data length L, and any other value is used as 8. Word bits at index L and above are 0.
- R6: With `cfg_msb_first`=0 the first received data bit is word bit 0. With `cfg_msb_first`=1 it is word bit L-1.
- R7: `cfg_parity` encodings: 0 none (no parity slot; stop follows the last data bit), 1 odd (ones in data plus parity bit is odd), 2 even (that count is even), 3 bit must be 0, 4 bit must be 1, 5 always passes. Codes 6 and 7 act as none.
- R8: A parity failure sets `rx_parity_err`=1 and `rx_frame_ok`=0, and the word is still delivered.
- R9: Only the stop slot is checked after parity. If it reads 0, `rx_frame_err`=1 and `rx_frame_ok`=0 with the word still delivered. The block is back in idle on the next clock.
- R10: With `cfg_invert`=1 the raw line is inverted before any decoding, so the idle level is 0 and the start edge is a rising raw edge.
- R11: Transitions during a frame do not start a new frame. Each frame gives exactly one single-cycle strobe, and the word and flags hold between strobes.
- R12: Length, parity, order, inversion, clocks per bit and sample offset are captured at the start edge. Changes after that affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Raw asynchronous serial line |
| cfg_cpb | input | CPB_W | Clock cycles per bit (at least 2) |
| cfg_len | input | 4 | Data length, 5 to 9 |
| cfg_parity | input | 3 | Parity mode code |
| cfg_msb_first | input | 1 | 1 = first data bit is the most significant |
| cfg_invert | input | 1 | 1 = invert the raw line |
| cfg_pct | input | 7 | Sample position as percent of the bit period |
| rx_strobe | output | 1 | One-cycle pulse at the end of each frame |
| rx_word | output | WORD_W | Received data word |
| rx_frame_ok | output | 1 | Frame had no error |
| rx_frame_err | output | 1 | Bad start or bad stop bit |
| rx_parity_err | output | 1 | Parity check failed |

## Verification
The bench builds the block with its default parameters: a 16-bit clocks-per-bit field, a 9-bit word and a two-stage synchronizer. It programs 8 and 10 clocks per bit so that frames stay short. At 10 clocks per bit the percentages 1, 20, 50 and 99 give offsets 0, 1, 4 and 8. The bench corrupts either the first three or the last two clocks of every data bit, so the word decoded shows which offset was used. An offset of 0 also makes the start read coincide with the start edge itself. Because the word is 9 bits wide, all five data lengths can be reached.

// File: rtl/uart_sp_pkg.sv
package uart_sp_pkg;

    localparam int PCT_W = 7;
    localparam int LEN_W = 4;

    typedef enum logic [2:0] {
        PAR_NONE   = 3'd0,
        PAR_ODD    = 3'd1,
        PAR_EVEN   = 3'd2,
        PAR_ZERO   = 3'd3,
        PAR_ONE    = 3'd4,
        PAR_IGNORE = 3'd5,
        PAR_RSV6   = 3'd6,
        PAR_RSV7   = 3'd7
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        par_mode_e        par;
        logic             msb_first;
        logic             invert;
    } frame_cfg_t;

    // Out-of-range percentages fall back to mid-bit.
    function automatic logic [PCT_W-1:0] eff_pct(input logic [PCT_W-1:0] p);
        return (p >= 7'd1 && p <= 7'd99) ? p : 7'd50;
    endfunction

    function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
        return (l >= 4'd5 && l <= 4'd9) ? l : 4'd8;
    endfunction

    function automatic par_mode_e eff_par(input logic [2:0] m);
        return (m > 3'd5) ? PAR_NONE : par_mode_e'(m);
    endfunction

    // data_odd is the XOR of all data bits.
    function automatic logic parity_pass(input par_mode_e m, input logic data_odd,
                                         input logic pbit);
        case (m)
            PAR_ODD:  return (data_odd ^ pbit) == 1'b1;
            PAR_EVEN: return (data_odd ^ pbit) == 1'b0;
            PAR_ZERO: return pbit == 1'b0;
            PAR_ONE:  return pbit == 1'b1;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_sp_sync.sv
module uart_sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_raw,
    input  logic invert,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain    <= '1;
            prev_raw <= 1'b1;
        end else begin
            chain    <= {chain[STAGES-2:0], rx_raw};
            prev_raw <= chain[STAGES-1];
        end
    end

    assign line_o = chain[STAGES-1] ^ invert;
    assign fall_o = (prev_raw ^ invert) & ~line_o;
endmodule

// File: rtl/uart_sp_bittimer.sv
module uart_sp_bittimer #(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             active,
    input  logic [CPB_W-1:0] cpb,
    input  logic [CPB_W-1:0] off,
    output logic             hit
);
    localparam logic [CPB_W-1:0] ONE = CPB_W'(1);

    logic [CPB_W-1:0] pos;

    // The launch clock is position 0, so the next clock is position 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (launch) begin
            pos <= ONE;
        end else if (active) begin
            pos <= (pos == cpb - ONE) ? '0 : pos + ONE;
        end
    end

    assign hit = active && (pos == off);
endmodule

// File: rtl/uart_sp_frame.sv
module uart_sp_frame
    import uart_sp_pkg::*;
#(
    parameter int CPB_W  = 16,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              line,
    input  logic              hit,
    input  logic [CPB_W-1:0]  cfg_cpb,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [2:0]        cfg_parity,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic [PCT_W-1:0]  cfg_pct,
    output logic              launch,
    output logic              active,
    output logic              inv_eff,
    output logic [CPB_W-1:0]  cpb_q,
    output logic [CPB_W-1:0]  off_q,
    output rx_state_e         state,
    output logic [LEN_W-1:0]  len_q,
    output logic              rx_strobe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_frame_ok,
    output logic              rx_frame_err,
    output logic              rx_parity_err
);
    localparam int PROD_W = CPB_W + PCT_W;

    frame_cfg_t        cfg_q;
    logic [LEN_W-1:0]  bit_idx;
    logic [LEN_W-1:0]  wr_idx;
    logic [WORD_W-1:0] acc;
    logic              par_bad;
    logic [PROD_W-1:0] prod;
    logic [CPB_W-1:0]  off_next;

    // The offset is computed once per frame, at the start edge.
    assign prod     = PROD_W'(cfg_cpb - CPB_W'(1)) * PROD_W'(eff_pct(cfg_pct));
    assign off_next = CPB_W'(prod / PROD_W'(100));

    assign launch  = (state == ST_IDLE) && fall;
    assign active  = (state != ST_IDLE);
    assign inv_eff = active ? cfg_q.invert : cfg_invert;
    assign len_q   = cfg_q.len;
    assign wr_idx  = cfg_q.msb_first ? (cfg_q.len - 4'd1 - bit_idx) : bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cfg_q         <= '{len: 4'd8, par: PAR_NONE, msb_first: 1'b0, invert: 1'b0};
            cpb_q         <= '0;
            off_q         <= '0;
            bit_idx       <= '0;
            acc           <= '0;
            par_bad       <= 1'b0;
            rx_strobe     <= 1'b0;
            rx_word       <= '0;
            rx_frame_ok   <= 1'b0;
            rx_frame_err  <= 1'b0;
            rx_parity_err <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            case (state)
                ST_IDLE: if (fall) begin
                    cfg_q   <= '{len: eff_len(cfg_len), par: eff_par(cfg_parity),
                                 msb_first: cfg_msb_first, invert: cfg_invert};
                    cpb_q   <= cfg_cpb;
                    off_q   <= off_next;
                    bit_idx <= '0;
                    acc     <= '0;
                    par_bad <= 1'b0;
                    // An offset of 0 reads the start slot at the edge itself, where it is low.
                    state   <= (off_next == '0) ? ST_DATA : ST_START;
                end
                ST_START: if (hit) begin
                    if (line) begin
                        rx_strobe     <= 1'b1;
                        rx_word       <= '0;
                        rx_frame_ok   <= 1'b0;
                        rx_frame_err  <= 1'b1;
                        rx_parity_err <= 1'b0;
                        state         <= ST_IDLE;
                    end else begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: if (hit) begin
                    acc     <= acc | (WORD_W'(line) << wr_idx);
                    bit_idx <= bit_idx + 4'd1;
                    if (bit_idx == cfg_q.len - 4'd1) begin
                        state <= (cfg_q.par == PAR_NONE) ? ST_STOP : ST_PARITY;
                    end
                end
                ST_PARITY: if (hit) begin
                    par_bad <= ~parity_pass(cfg_q.par, ^acc, line);
                    state   <= ST_STOP;
                end
                ST_STOP: if (hit) begin
                    rx_strobe     <= 1'b1;
                    rx_word       <= acc;
                    rx_frame_ok   <= line & ~par_bad;
                    rx_frame_err  <= ~line;
                    rx_parity_err <= par_bad;
                    state         <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_sp_rx.sv
module uart_sp_rx
    import uart_sp_pkg::*;
#(
    parameter int CPB_W       = 16,
    parameter int WORD_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_in,
    input  logic [CPB_W-1:0]  cfg_cpb,
    input  logic [3:0]        cfg_len,
    input  logic [2:0]        cfg_parity,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic [6:0]        cfg_pct,
    output logic              rx_strobe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_frame_ok,
    output logic              rx_frame_err,
    output logic              rx_parity_err
);
    logic             line_n;
    logic             fall;
    logic             launch;
    logic             active;
    logic             inv_eff;
    logic             hit;
    logic [CPB_W-1:0] cpb_q;
    logic [CPB_W-1:0] off_q;
    logic [LEN_W-1:0] len_q;
    rx_state_e        state;

    uart_sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .rx_raw (rx_in),
        .invert (inv_eff),
        .line_o (line_n),
        .fall_o (fall)
    );

    uart_sp_bittimer #(.CPB_W(CPB_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .active (active),
        .cpb    (cpb_q),
        .off    (off_q),
        .hit    (hit)
    );

    uart_sp_frame #(.CPB_W(CPB_W), .WORD_W(WORD_W)) u_frame (
        .clk           (clk),
        .rst           (rst),
        .fall          (fall),
        .line          (line_n),
        .hit           (hit),
        .cfg_cpb       (cfg_cpb),
        .cfg_len       (cfg_len),
        .cfg_parity    (cfg_parity),
        .cfg_msb_first (cfg_msb_first),
        .cfg_invert    (cfg_invert),
        .cfg_pct       (cfg_pct),
        .launch        (launch),
        .active        (active),
        .inv_eff       (inv_eff),
        .cpb_q         (cpb_q),
        .off_q         (off_q),
        .state         (state),
        .len_q         (len_q),
        .rx_strobe     (rx_strobe),
        .rx_word       (rx_word),
        .rx_frame_ok   (rx_frame_ok),
        .rx_frame_err  (rx_frame_err),
        .rx_parity_err (rx_parity_err)
    );
endmodule

// File: rtl/uart_sp_rx_chk.sv
module uart_sp_rx_chk
    import uart_sp_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst,
    input rx_state_e         state,
    input logic              hit,
    input logic              line_n,
    input logic [LEN_W-1:0]  len_q,
    input logic              rx_strobe,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_frame_ok,
    input logic              rx_frame_err,
    input logic              rx_parity_err
);
    p_hit_sparse_r2: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    p_start_abort_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && hit && line_n) |=>
            (rx_strobe && rx_frame_err && !rx_frame_ok && !rx_parity_err && rx_word == '0));

    p_word_fit_r5: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |-> ((rx_word >> len_q) == '0));

    p_parity_kills_ok_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && rx_parity_err) |-> !rx_frame_ok);

    p_stop_end_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && hit) |=>
            (rx_strobe && state == ST_IDLE && rx_frame_err == !$past(line_n)));

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_strobe);

    p_word_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rx_strobe |-> $stable(rx_word));
endmodule

bind uart_sp_rx uart_sp_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .state         (state),
    .hit           (hit),
    .line_n        (line_n),
    .len_q         (len_q),
    .rx_strobe     (rx_strobe),
    .rx_word       (rx_word),
    .rx_frame_ok   (rx_frame_ok),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_err (rx_parity_err)
);

// File: tb/uart_sp_rx_tb.sv
`timescale 1ns/1ps
module uart_sp_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_in = 1'b1;
    logic [15:0] cfg_cpb = 16'd8;
    logic [3:0]  cfg_len = 4'd8;
    logic [2:0]  cfg_parity = 3'd0;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_invert = 1'b0;
    logic [6:0]  cfg_pct = 7'd50;
    logic        rx_strobe;
    logic [8:0]  rx_word;
    logic        rx_frame_ok, rx_frame_err, rx_parity_err;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    uart_sp_rx u_dut (
        .clk(clk), .rst(rst), .rx_in(rx_in), .cfg_cpb(cfg_cpb), .cfg_len(cfg_len),
        .cfg_parity(cfg_parity), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
        .cfg_pct(cfg_pct), .rx_strobe(rx_strobe), .rx_word(rx_word),
        .rx_frame_ok(rx_frame_ok), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err)
    );

    // Behavioural reference model, evaluated on every rising edge.
    bit m_d1, m_d2, m_d3;          // raw line delayed by 1, 2 and 3 clocks
    bit m_active;
    int cyc, m_t0, m_slot, m_cpb, m_off, m_len, m_par, m_acc;
    bit m_msb, m_inv, m_pbad;
    bit e_strobe, e_ok, e_ferr, e_perr;
    int e_word;

    always @(posedge clk) begin
        bit cur, pre, inv;
        int p, ones, pass, idx;
        if (rst) begin
            m_d1 = 1; m_d2 = 1; m_d3 = 1; m_active = 0; cyc = 0;
            e_strobe = 0; e_ok = 0; e_ferr = 0; e_perr = 0; e_word = 0;
        end else begin
            e_strobe = 0;
            inv = m_active ? m_inv : cfg_invert;
            cur = m_d2 ^ inv;
            pre = m_d3 ^ inv;
            if (!m_active && pre && !cur) begin
                m_active = 1; m_t0 = cyc; m_slot = 0; m_acc = 0; m_pbad = 0;
                m_cpb = cfg_cpb;
                p = cfg_pct; if (p < 1 || p > 99) p = 50;
                m_off = ((m_cpb - 1) * p) / 100;
                m_len = cfg_len; if (m_len < 5 || m_len > 9) m_len = 8;
                m_par = cfg_parity; if (m_par > 5) m_par = 0;
                m_msb = cfg_msb_first; m_inv = cfg_invert;
            end
            if (m_active && (cyc - m_t0) == m_slot * m_cpb + m_off) begin
                if (m_slot == 0) begin
                    if (cur) begin
                        e_strobe = 1; e_word = 0; e_ok = 0; e_ferr = 1; e_perr = 0;
                        m_active = 0;
                    end else m_slot++;
                end else if (m_slot <= m_len) begin
                    idx = m_msb ? (m_len - m_slot) : (m_slot - 1);
                    if (cur) m_acc = m_acc | (1 << idx);
                    m_slot++;
                end else if (m_slot == m_len + 1 && m_par != 0) begin
                    ones = 0;
                    for (int i = 0; i < 9; i++) ones += (m_acc >> i) & 1;
                    ones += cur;
                    case (m_par)
                        1: pass = (ones % 2) == 1;
                        2: pass = (ones % 2) == 0;
                        3: pass = (cur == 0);
                        4: pass = (cur == 1);
                        default: pass = 1;
                    endcase
                    m_pbad = !pass;
                    m_slot++;
                end else begin
                    e_strobe = 1; e_word = m_acc; e_ferr = !cur; e_perr = m_pbad;
                    e_ok = cur && !m_pbad;
                    m_active = 0;
                end
            end
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = rx_in; cyc++;
        end
    end

    // Per-cycle comparison against the model, plus frame capture.
    int got_cnt = 0;
    int got_word;
    bit got_ok, got_ferr, got_perr;

    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if (rx_strobe !== e_strobe || rx_word !== 9'(e_word) || rx_frame_ok !== e_ok ||
                rx_frame_err !== e_ferr || rx_parity_err !== e_perr) begin
                n_fail++;
                $display("FAIL %s cycle %0d: got stb=%b word=%h ok=%b ferr=%b perr=%b exp stb=%b word=%h ok=%b ferr=%b perr=%b",
                         cur_req, cyc, rx_strobe, rx_word, rx_frame_ok, rx_frame_err, rx_parity_err,
                         e_strobe, 9'(e_word), e_ok, e_ferr, e_perr);
            end
            if (rx_strobe) begin
                got_cnt++; got_word = rx_word; got_ok = rx_frame_ok;
                got_ferr = rx_frame_err; got_perr = rx_parity_err;
            end
        end
    end

    task automatic do_reset(input bit inv);
        rst = 1'b1;
        cfg_invert = inv;
        rx_in = ~inv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic hold(input bit v, input int n);
        rx_in = v ^ cfg_invert;
        repeat (n) @(negedge clk);
    endtask

    // corrupt: 0 clean, 1 first three clocks of each data bit flipped, 2 last two flipped.
    // pbit < 0 sends no parity slot. mid: change length and percentage after the start bit.
    task automatic send(input int data, input int len, input bit msb, input int pbit,
                        input bit stopv, input int corrupt, input bit mid);
        int  cpb;
        bit  b, v;
        cpb = cfg_cpb;
        hold(1'b0, cpb);
        if (mid) begin cfg_len = 4'd5; cfg_pct = 7'd99; end
        for (int i = 0; i < len; i++) begin
            b = msb ? ((data >> (len - 1 - i)) & 1) : ((data >> i) & 1);
            for (int c = 0; c < cpb; c++) begin
                v = b;
                if (corrupt == 1 && c < 3) v = !b;
                if (corrupt == 2 && c >= cpb - 2) v = !b;
                hold(v, 1);
            end
        end
        if (pbit >= 0) hold(pbit[0], cpb);
        hold(stopv, cpb);
        hold(1'b1, 3 * cpb);
    endtask

    task automatic chk(input string req, input int cnt0, input int word, input bit ok,
                       input bit ferr, input bit perr);
        n_checks++;
        if (got_cnt != cnt0 + 1 || got_word != word || got_ok != ok ||
            got_ferr != ferr || got_perr != perr) begin
            n_fail++;
            $display("FAIL %s frame: got n=%0d word=%h ok=%b ferr=%b perr=%b exp n=%0d word=%h ok=%b ferr=%b perr=%b",
                     req, got_cnt - cnt0, got_word, got_ok, got_ferr, got_perr,
                     1, word, ok, ferr, perr);
        end
    endtask

    initial begin
        int c0;
        do_reset(1'b0);
        cur_req = "R1";
        n_checks++;
        if (rx_strobe || rx_word != 0 || rx_frame_ok || rx_frame_err || rx_parity_err) begin
            n_fail++;
            $display("FAIL R1 reset: got stb=%b word=%h ok=%b ferr=%b perr=%b exp all 0",
                     rx_strobe, rx_word, rx_frame_ok, rx_frame_err, rx_parity_err);
        end

        // R2 / R11: plain 8N1, LSB first, many in-frame edges.
        cur_req = "R2";
        c0 = got_cnt; send(32'hA5, 8, 0, -1, 1, 0, 0); chk("R2", c0, 9'hA5, 1, 0, 0);
        cur_req = "R11";
        c0 = got_cnt; send(32'h55, 8, 0, -1, 1, 0, 0); chk("R11", c0, 9'h55, 1, 0, 0);

        // R6: bit order.
        cur_req = "R6";
        cfg_msb_first = 1;
        c0 = got_cnt; send(32'h01, 8, 0, -1, 1, 0, 0); chk("R6", c0, 9'h80, 1, 0, 0);
        c0 = got_cnt; send(32'hA5, 8, 1, -1, 1, 0, 0); chk("R6", c0, 9'hA5, 1, 0, 0);

        // R5: lengths.
        cur_req = "R5";
        cfg_len = 5;
        c0 = got_cnt; send(32'h01, 5, 0, -1, 1, 0, 0); chk("R5", c0, 9'h10, 1, 0, 0);
        cfg_msb_first = 0;
        c0 = got_cnt; send(32'h13, 5, 0, -1, 1, 0, 0); chk("R5", c0, 9'h13, 1, 0, 0);
        cfg_len = 9;
        c0 = got_cnt; send(32'h1A5, 9, 0, -1, 1, 0, 0); chk("R5", c0, 9'h1A5, 1, 0, 0);
        cfg_len = 3;
        c0 = got_cnt; send(32'hC3, 8, 0, -1, 1, 0, 0); chk("R5", c0, 9'hC3, 1, 0, 0);
        cfg_len = 8;

        // R7 / R8: parity modes.
        cur_req = "R7";
        cfg_parity = 2;
        c0 = got_cnt; send(32'h3C, 8, 0, 0, 1, 0, 0); chk("R7", c0, 9'h3C, 1, 0, 0);
        cur_req = "R8";
        c0 = got_cnt; send(32'h3C, 8, 0, 1, 1, 0, 0); chk("R8", c0, 9'h3C, 0, 0, 1);
        cur_req = "R7";
        cfg_parity = 1;
        c0 = got_cnt; send(32'h01, 8, 0, 0, 1, 0, 0); chk("R7", c0, 9'h01, 1, 0, 0);
        c0 = got_cnt; send(32'h03, 8, 0, 0, 1, 0, 0); chk("R7", c0, 9'h03, 0, 0, 1);
        cfg_parity = 3;
        c0 = got_cnt; send(32'h0F, 8, 0, 1, 1, 0, 0); chk("R7", c0, 9'h0F, 0, 0, 1);
        cfg_parity = 4;
        c0 = got_cnt; send(32'h0F, 8, 0, 1, 1, 0, 0); chk("R7", c0, 9'h0F, 1, 0, 0);
        cfg_parity = 5;
        c0 = got_cnt; send(32'h0E, 8, 0, 0, 1, 0, 0); chk("R7", c0, 9'h0E, 1, 0, 0);
        c0 = got_cnt; send(32'h0E, 8, 0, 1, 1, 0, 0); chk("R7", c0, 9'h0E, 1, 0, 0);
        cfg_parity = 7;
        c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 0, 0); chk("R7", c0, 9'h5A, 1, 0, 0);
        cfg_parity = 0;

        // R9: bad stop bit.
        cur_req = "R9";
        c0 = got_cnt; send(32'h77, 8, 0, -1, 0, 0, 0); chk("R9", c0, 9'h77, 0, 1, 0);

        // R4: false start (two low clocks, read at offset 3).
        cur_req = "R4";
        c0 = got_cnt; hold(1'b0, 2); hold(1'b1, 40); chk("R4", c0, 0, 0, 1, 0);

        // R2 / R3: sample position at 10 clocks per bit.
        cfg_cpb = 10;
        cur_req = "R2";
        cfg_pct = 50;  c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 1, 0); chk("R2", c0, 9'h5A, 1, 0, 0);
        cfg_pct = 1;   c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 1, 0); chk("R2", c0, 9'hA5, 1, 0, 0);
        cfg_pct = 20;  c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 1, 0); chk("R2", c0, 9'hA5, 1, 0, 0);
        cfg_pct = 99;  c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 2, 0); chk("R2", c0, 9'hA5, 1, 0, 0);
        cfg_pct = 50;  c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 2, 0); chk("R2", c0, 9'h5A, 1, 0, 0);
        cur_req = "R3";
        cfg_pct = 0;   c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 1, 0); chk("R3", c0, 9'h5A, 1, 0, 0);
        cfg_pct = 120; c0 = got_cnt; send(32'h5A, 8, 0, -1, 1, 2, 0); chk("R3", c0, 9'h5A, 1, 0, 0);

        // R12: configuration changed after the start bit.
        cur_req = "R12";
        cfg_pct = 50;
        c0 = got_cnt; send(32'hE7, 8, 0, -1, 1, 2, 1); chk("R12", c0, 9'hE7, 1, 0, 0);
        cfg_len = 8; cfg_pct = 50;

        // R10: inverted line.
        cur_req = "R10";
        do_reset(1'b1);
        c0 = got_cnt; send(32'h96, 8, 0, -1, 1, 0, 0); chk("R10", c0, 9'h96, 1, 0, 0);
        c0 = got_cnt; send(32'h21, 8, 0, -1, 0, 0, 0); chk("R10", c0, 9'h21, 0, 1, 0);

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: %s run did not finish, got timeout exp completion", cur_req);
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule